// File: doc/BRIEF.md
# Multichannel Edge-Programmed PWM Generator

This block generates up to sixteen pulse-width-modulated outputs that share one time base. An 8-bit prescaler divides the input clock into step ticks. An 8-bit step counter counts those ticks and wraps once per PWM period. Each channel has no duty-cycle register. Software instead programs the step at which the output goes high and the step at which it goes low. Equal rise and fall steps make the output toggle once per period. A step value beyond the period end never fires, which gives constant-high or constant-low outputs.

Channels picked by a parameter mask buffer their edge writes in shadow registers. Software writes new edges to those channels and then requests a commit through a global sync register. The commit lands on the next period boundary, so the waveform never shows a partly updated pair of edges. Channels outside the mask take edge writes at once. The block is reached through a simple word-addressed register port: one write strobe and a combinational read path.

Top module: `edge_pwm`

## Requirements
- R1: The PWM period is (PRESCALE+1)·(PERIOD+1) input clocks. Step n spans clocks n·(PRESCALE+1) to n·(PRESCALE+1)+PRESCALE of the period. An output changes only in the clock that follows the first clock of a step, or because its channel is disabled.
- R2: An enabled channel goes high at the step equal to its rise value and low at the step equal to its fall value. A fall value below the rise value therefore gives an inverted waveform.
- R3: When the rise and fall values are equal, the output inverts once per period at that step. This gives a 50% waveform at twice the period.
- R4: An edge value greater than PERIOD never fires. Rise 0 with fall PERIOD+1 holds the output high, and rise PERIOD+1 holds it low.
- R5: Byte addresses of 32-bit words: prescale 0x00 and period 0x04, bits [7:0]. Enables for channels 0–7 at 0x08 and channels 8–15 at 0x0C, one bit per channel (bit = channel mod 8). Channel i has its rise value at 0x10+8·i and its fall value at 0x14+8·i, bits [7:0].
- R6: A channel whose enable bit is 0 drives its output low from the next clock on and keeps its edge values. Enable writes act at once on every channel.
- R7: On a channel whose shadow-mask bit is 0, an edge write changes the waveform and the readback without any sync request.
- R8: On a channel whose shadow-mask bit is 1, an edge write goes to a hidden copy, and reads return the active value. Writing 1 in bit 0 of 0xE4 loads every shadowed channel at the next period boundary, all in the same clock.
- R9: The sync request clears itself when it is applied, and 0xE4 always reads 0.
- R10: After reset, every register reads 0 and every output is low. Addresses with no register (0x90 and above) read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
A table of prescale, period, rise and fall settings drives the main function. For each setting the bench counts the high clocks and rising transitions over four full periods, so the result does not depend on where the period starts. The settings cover normal order, where fall follows rise. They also cover inverted order, equal edges, and both suppressed-edge forms. Unit prescale is compared with longer prescales, so that errors in the step-size scaling stand apart from errors in the compare logic. Directed tests then time a sync request against a visible period start. They show that shadowed edges stay hidden until the boundary and that disabled channels go low but keep their edges.

// File: rtl/edge_pwm.sv
`timescale 1ns/1ps
module edge_pwm #(
  parameter int NCH = 16,
  parameter logic [15:0] SHADOW_MASK = 16'hAAAA
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NCH-1:0]  pwm_out
);
  localparam logic [5:0] W_PRE  = 6'd0;
  localparam logic [5:0] W_PER  = 6'd1;
  localparam logic [5:0] W_SYNC = 6'd57;

  logic [7:0] presc_q, per_q, pre_cnt, step_cnt;
  logic       sync_pend;
  logic [NCH-1:0] en_vec;
  logic [7:0] rise_a [NCH];
  logic [7:0] fall_a [NCH];
  logic [15:0] en16;
  logic unused_bits;

  wire [5:0] widx      = bus_addr[7:2];
  wire       tick      = pre_cnt >= presc_q;
  wire       last_step = step_cnt >= per_q;
  wire       bound     = tick && last_step;
  wire       step_start = pre_cnt == 8'd0;
  wire       sync_wr   = bus_we && widx == W_SYNC && bus_wdata[0];
  wire       commit    = bound && sync_pend;

  assign unused_bits = ^{bus_wdata[31:8], bus_addr[1:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      presc_q <= '0;
      per_q   <= '0;
    end else if (bus_we) begin
      if (widx == W_PRE) presc_q <= bus_wdata[7:0];
      if (widx == W_PER) per_q   <= bus_wdata[7:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_cnt  <= '0;
      step_cnt <= '0;
    end else if (tick) begin
      pre_cnt  <= '0;
      step_cnt <= last_step ? 8'd0 : step_cnt + 8'd1;
    end else begin
      pre_cnt <= pre_cnt + 8'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       sync_pend <= 1'b0;
    else if (sync_wr) sync_pend <= 1'b1;
    else if (bound)   sync_pend <= 1'b0;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [5:0] W_EN   = 6'(2 + g / 8);
    localparam logic [5:0] W_RISE = 6'(4 + 2 * g);
    localparam logic [5:0] W_FALL = 6'(5 + 2 * g);
    wire wr_rise = bus_we && widx == W_RISE;
    wire wr_fall = bus_we && widx == W_FALL;
    logic en_c, oq;
    logic [7:0] ra, fa;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) en_c <= 1'b0;
      else if (bus_we && widx == W_EN) en_c <= bus_wdata[g % 8];

    if (SHADOW_MASK[g]) begin : g_shadow
      logic [7:0] rs, fs;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          rs <= '0;
          fs <= '0;
        end else begin
          if (wr_rise) rs <= bus_wdata[7:0];
          if (wr_fall) fs <= bus_wdata[7:0];
        end
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          ra <= '0;
          fa <= '0;
        end else if (commit) begin
          ra <= rs;
          fa <= fs;
        end
    end else begin : g_direct
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          ra <= '0;
          fa <= '0;
        end else begin
          if (wr_rise) ra <= bus_wdata[7:0];
          if (wr_fall) fa <= bus_wdata[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          oq <= 1'b0;
      else if (!en_c)      oq <= 1'b0;
      else if (step_start) begin
        if (step_cnt == ra && step_cnt == fa) oq <= ~oq;
        else if (step_cnt == ra)              oq <= 1'b1;
        else if (step_cnt == fa)              oq <= 1'b0;
      end

    assign en_vec[g]  = en_c;
    assign rise_a[g]  = ra;
    assign fall_a[g]  = fa;
    assign pwm_out[g] = oq;
  end

  always_comb begin
    en16 = '0;
    en16[NCH-1:0] = en_vec;
  end

  always_comb begin
    bus_rdata = '0;
    case (widx)
      W_PRE:   bus_rdata[7:0] = presc_q;
      W_PER:   bus_rdata[7:0] = per_q;
      6'd2:    bus_rdata[7:0] = en16[7:0];
      6'd3:    bus_rdata[7:0] = en16[15:8];
      default: ;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (widx == 6'(4 + 2 * i)) bus_rdata[7:0] = rise_a[i];
      if (widx == 6'(5 + 2 * i)) bus_rdata[7:0] = fall_a[i];
    end
  end
endmodule

// File: rtl/edge_pwm_chk.sv
`timescale 1ns/1ps
module edge_pwm_chk #(
  parameter int NCH = 16,
  parameter logic [15:0] SHADOW_MASK = 16'hAAAA
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_we,
  input logic [7:0]     bus_addr,
  input logic [31:0]    bus_wdata,
  input logic [31:0]    bus_rdata,
  input logic [NCH-1:0] pwm_out,
  input logic [NCH-1:0] en_vec,
  input logic [7:0]     pre_cnt,
  input logic           sync_pend,
  input logic           bound,
  input logic [7:0]     rise_a [NCH],
  input logic [7:0]     fall_a [NCH]
);
  logic unused_chk;
  assign unused_chk = ^{bus_wdata[31:8], bus_addr[1:0]};
  wire [5:0] widx    = bus_addr[7:2];
  wire       sync_wr = bus_we && widx == 6'd57 && bus_wdata[0];

  p_step_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pre_cnt) != 8'd0) |-> (((pwm_out ^ $past(pwm_out)) & $past(en_vec)) == '0));

  p_dis_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & ~$past(en_vec)) == '0);

  p_sync_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bound && sync_pend && !sync_wr) |=> !sync_pend);

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (widx >= 6'd36) |-> (bus_rdata == 32'd0));

  for (genvar g = 0; g < NCH; g++) begin : g_c
    if (SHADOW_MASK[g]) begin : g_s
      p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bound && sync_pend) |=> ($stable(rise_a[g]) && $stable(fall_a[g])));
    end else begin : g_d
      p_direct_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (widx == 6'(4 + 2 * g) || widx == 6'(5 + 2 * g)))
        |=> ($stable(rise_a[g]) && $stable(fall_a[g])));
    end
  end
endmodule

bind edge_pwm edge_pwm_chk #(.NCH(NCH), .SHADOW_MASK(SHADOW_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out),
  .en_vec(en_vec), .pre_cnt(pre_cnt), .sync_pend(sync_pend), .bound(bound),
  .rise_a(rise_a), .fall_a(fall_a)
);

// File: tb/edge_pwm_bench.sv
`timescale 1ns/1ps
module edge_pwm_bench;
  localparam int NCH = 16;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] pwm_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edge_pwm u_edge_pwm (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  // columns: prescale, period, rise, fall, high clocks in 4 periods, rises in 4 periods
  localparam logic [7:0] VEC [8][6] = '{
    '{8'd1, 8'd3, 8'd0, 8'd2, 8'd16, 8'd4},
    '{8'd1, 8'd3, 8'd3, 8'd2, 8'd24, 8'd4},
    '{8'd1, 8'd3, 8'd0, 8'd4, 8'd32, 8'd0},
    '{8'd1, 8'd3, 8'd4, 8'd0, 8'd0,  8'd0},
    '{8'd1, 8'd3, 8'd2, 8'd2, 8'd16, 8'd2},
    '{8'd0, 8'd9, 8'd2, 8'd7, 8'd20, 8'd4},
    '{8'd0, 8'd9, 8'd9, 8'd0, 8'd4,  8'd4},
    '{8'd2, 8'd5, 8'd1, 8'd5, 8'd48, 8'd4}
  };

  function automatic string vtag(int i);
    case (i)
      0, 1, 6: return "R2 edge order";
      2, 3:    return "R4 suppressed edge";
      4:       return "R3 equal edges";
      default: return "R1 period scaling";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output int d);
    @(negedge clk);
    bus_addr = a;
    #1 d = int'(bus_rdata);
  endtask

  task automatic measure(int ch, int win, output int hi, output int rises);
    logic prev;
    hi = 0; rises = 0;
    @(negedge clk);
    prev = pwm_out[ch];
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
      if (pwm_out[ch] && !prev) rises++;
      prev = pwm_out[ch];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d, hi, rs, p;
    repeat (3) @(negedge clk);
    chk("R10 reset output", int'(pwm_out), 0);
    rst_n = 1'b1;
    rd(8'h00, d); chk("R10 reset prescale", d, 0);
    rd(8'h04, d); chk("R10 reset period", d, 0);
    rd(8'h08, d); chk("R10 reset enable", d, 0);
    rd(8'h14, d); chk("R10 reset fall", d, 0);
    rd(8'h90, d); chk("R10 unmapped 0x90", d, 0);
    rd(8'hFC, d); chk("R10 unmapped 0xFC", d, 0);

    for (int v = 0; v < 8; v++) begin
      wr(8'h00, 32'(VEC[v][0]));
      wr(8'h04, 32'(VEC[v][1]));
      wr(8'h10, 32'(VEC[v][2]));
      wr(8'h14, 32'(VEC[v][3]));
      wr(8'h08, 32'h1);
      p = (int'(VEC[v][0]) + 1) * (int'(VEC[v][1]) + 1);
      repeat (3 * p + 4) @(negedge clk);
      measure(0, 4 * p, hi, rs);
      chk({vtag(v), " high"}, hi, int'(VEC[v][4]));
      chk({vtag(v), " rises"}, rs, int'(VEC[v][5]));
    end

    // R5 register placement
    rd(8'h00, d); chk("R5 prescale at 0x00", d, 2);
    rd(8'h04, d); chk("R5 period at 0x04", d, 5);
    wr(8'h80, 32'h7);
    rd(8'h80, d); chk("R5 ch14 rise at 0x80 (R7 direct)", d, 7);

    // R6 disable holds low and keeps edges
    wr(8'h08, 32'h0);
    measure(0, 40, hi, rs);
    chk("R6 disabled output", hi, 0);
    rd(8'h10, d); chk("R6 rise kept", d, 1);
    rd(8'h14, d); chk("R6 fall kept", d, 5);

    // R8/R9 shadowed channels 1 and 3
    wr(8'h00, 32'h0);
    wr(8'h04, 32'd9);
    wr(8'h10, 32'd0);
    wr(8'h14, 32'd1);
    wr(8'h18, 32'd1);
    wr(8'h1C, 32'd6);
    wr(8'h28, 32'd3);
    wr(8'h2C, 32'd8);
    wr(8'h08, 32'h0B);
    rd(8'h18, d); chk("R8 shadow write hidden", d, 0);
    wr(8'hE4, 32'h1);
    repeat (25) @(negedge clk);
    rd(8'h18, d); chk("R8 ch1 rise after sync", d, 1);
    rd(8'h2C, d); chk("R8 ch3 fall after sync", d, 8);
    rd(8'hE4, d); chk("R9 sync reads zero", d, 0);
    measure(1, 40, hi, rs);
    chk("R8 ch1 duty after sync", hi, 20);
    wr(8'h18, 32'd2);
    wr(8'h1C, 32'd4);
    wr(8'h2C, 32'd5);
    rd(8'h18, d); chk("R8 readback shows active", d, 1);
    measure(1, 40, hi, rs);
    chk("R8 pending write no effect", hi, 20);
    // align to a visible period start on channel 0 (rise 0, fall 1)
    begin
      logic prev;
      @(negedge clk); prev = pwm_out[0];
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (pwm_out[0] && !prev) break;
        prev = pwm_out[0];
      end
    end
    wr(8'hE4, 32'h1);
    rd(8'h18, d); chk("R8 no load before boundary", d, 1);
    repeat (15) @(negedge clk);
    rd(8'h18, d); chk("R8 ch1 rise loaded", d, 2);
    rd(8'h2C, d); chk("R8 ch3 fall loaded", d, 5);
    rd(8'hE4, d); chk("R9 sync cleared", d, 0);
    measure(1, 40, hi, rs);
    chk("R8 ch1 new duty", hi, 8);
    measure(3, 40, hi, rs);
    chk("R8 ch3 new duty", hi, 8);

    // R6 upper enable register, channel 8 unshadowed
    wr(8'h50, 32'd0);
    wr(8'h54, 32'd5);
    wr(8'h0C, 32'h1);
    rd(8'h0C, d); chk("R6 upper enable readback", d, 1);
    repeat (12) @(negedge clk);
    measure(8, 40, hi, rs);
    chk("R6 channel 8 enabled duty", hi, 20);
    measure(0, 40, hi, rs);
    chk("R2 channel 0 narrow pulse", hi, 4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule